// File: doc/BRIEF.md
# Register-Programmed Serial Peripheral Master

This block is a serial peripheral (SPI) master driven through a small 32-bit register port. Software sets the clock mode, the clock divider and a chip select pattern in a configuration register. It switches the controller on, then writes bytes into a transmit queue. While the controller is on and the queue holds data, the block shifts out one byte after another, with no separate start command. Every byte shifted out captures one byte from the serial input, and that byte goes into a receive queue, which software empties by reading a data register.

A status register shows live queue flags and sticky overflow flags. The sticky flags are cleared by writing ones to them. A mask register, set through an enable register and cleared through a disable register, selects which status bits drive the interrupt output. Three active-low device selects are decoded from a four-bit field under software control, lowest device first.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset, the config register (byte offset 0x00) reads 0x00003C00, status (0x04) reads 0x00000004, the mask (0x10) reads 0, every `cs_n` bit is high, `sclk` is low and `irq` is low.
- R2: Device selects come from config bits 13:10 by priority. If bit 10 is 0, `cs_n[0]` goes low. Otherwise, if bit 11 is 0, `cs_n[1]` goes low. Otherwise, if bit 12 is 0, `cs_n[2]` goes low. Otherwise no select is low. At most one select is low at any time, and the selects change only after a register write.
- R3: While enable bit 0 at offset 0x14 is clear, no new byte starts. Queued bytes stay queued, and `sclk` stays at its idle level.
- R4: Config bit 1 (CPOL) sets the idle `sclk` level. With config bit 2 (CPHA) clear, data is valid on the first edge of each bit. With CPHA set, data is valid on the second edge. `mosi` sends the most significant bit first.
- R5: Each transmitted byte pushes exactly one received byte, built from `miso` on the same sampling edges, most significant bit first.
- R6: `sclk` runs at the reference clock divided by 2 << code, where the code is config bits 5:3. Each byte therefore holds `sclk` away from its idle level for 8 << code reference cycles.
- R7: Reading the receive data register (0x20) pops one byte into bits 7:0. When the receive queue is empty, the read returns 0 and leaves the queue unchanged.
- R8: Bytes written to the transmit data register (0x1C) are sent in write order, and the received bytes are read back in the same order. Each queue holds FIFO_DEPTH bytes.
- R9: The status bits are laid out as follows. Bit 0 is a sticky flag for a received byte dropped because the receive queue was full. Bit 2 shows that the transmit queue is not full. Bit 3 shows that the transmit queue is full. Bit 4 shows that the receive queue is not empty. Bit 5 shows that the receive queue is full. Bit 6 is a sticky flag for a write to a full transmit queue, and that write is discarded.
- R10: Writing a one to a sticky status bit clears it. Writes to status leave the live bits 2 to 5 unaffected.
- R11: Writing to 0x08 sets the mask bits that are written as one, and writing to 0x0C clears them. `irq` is the OR of the status bits ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x20) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 3 | Active-low device selects |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never both high. They also assume that the clock mode and the divider code stay fixed while a byte is being shifted. The bench writes the configuration only while the controller is off or both queues are empty, and it waits for each byte to arrive before it reconfigures. It drives `miso` as a direct or inverted loopback of `mosi`. This keeps the serial input stable between the edges the master samples.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int REG_AW = 6;
    localparam int REG_DW = 32;
    localparam int NSTAT  = 7;

    localparam logic [REG_AW-1:0] OFS_CFG  = 6'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
    localparam logic [REG_AW-1:0] OFS_IEN  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_IDIS = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_IMSK = 6'h10;
    localparam logic [REG_AW-1:0] OFS_ENA  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_TXD  = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_RXD  = 6'h20;

    localparam int ST_RXOVF  = 0;
    localparam int ST_TXNF   = 2;
    localparam int ST_TXFULL = 3;
    localparam int ST_RXNE   = 4;
    localparam int ST_RXFULL = 5;
    localparam int ST_TXOVF  = 6;

    typedef struct packed {
        logic       man_start;
        logic       man_sel;
        logic [3:0] sel;
        logic [3:0] pad;
        logic [2:0] div;
        logic       cpha;
        logic       cpol;
        logic       master;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{man_start: 1'b0, man_sel: 1'b0, sel: 4'hF,
                                   pad: 4'h0, div: 3'd0, cpha: 1'b0,
                                   cpol: 1'b0, master: 1'b0};

    typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;

    function automatic cfg_t cfg_from_word(logic [15:0] w);
        cfg_t c;
        c     = cfg_t'(w);
        c.pad = 4'h0;
        return c;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9
    push_not_full_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R7
    pop_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/spim_csdec.sv
module spim_csdec #(
    parameter int NCS = 3
) (
    input  logic [NCS-1:0] sel,
    output logic [NCS-1:0] cs_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_dev
        if (i == 0) begin : g_first
            assign cs_n[i] = sel[0];
        end else begin : g_rest
            assign cs_n[i] = ~(~sel[i] & (&sel[i-1:0]));
        end
    end

    // R2
    always_comb begin
        one_select_chk: assert ($onehot0(~cs_n));
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int BITS = 8,
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic            tx_avail,
    input  logic [BITS-1:0] tx_byte,
    output logic            tx_take,
    output logic            rx_push,
    output logic [BITS-1:0] rx_byte,
    input  logic            miso,
    output logic            sclk,
    output logic            mosi
);
    localparam int HCW = 1 << DIVW;
    localparam int ECW = $clog2(2 * BITS);
    localparam logic [ECW-1:0] LAST_EDGE = ECW'(2 * BITS - 1);

    sh_state_e       state;
    logic [HCW-1:0]  hcnt;
    logic [HCW-1:0]  half_lim;
    logic [ECW-1:0]  edge_cnt;
    logic [BITS-1:0] tx_sr, rx_sr, rx_nxt;
    logic            tick, lead, samp, shout;

    assign half_lim = (HCW'(1) << div) - HCW'(1);
    assign tx_take  = (state == SH_IDLE) && en && tx_avail;
    assign tick     = (state == SH_RUN) && (hcnt == half_lim);
    assign lead     = ~edge_cnt[0];
    assign samp     = lead ^ cpha;
    assign shout    = cpha ? lead : (!lead && edge_cnt != LAST_EDGE);
    assign rx_nxt   = samp ? {rx_sr[BITS-2:0], miso} : rx_sr;
    assign rx_push  = tick && (edge_cnt == LAST_EDGE);
    assign rx_byte  = rx_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SH_IDLE;
            hcnt     <= '0;
            edge_cnt <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
        end else if (state == SH_IDLE) begin
            sclk <= cpol;
            if (tx_take) begin
                state    <= SH_RUN;
                hcnt     <= '0;
                edge_cnt <= '0;
                if (cpha) begin
                    tx_sr <= tx_byte;
                end else begin
                    mosi  <= tx_byte[BITS-1];
                    tx_sr <= tx_byte << 1;
                end
            end
        end else begin
            if (tick) begin
                hcnt     <= '0;
                sclk     <= ~sclk;
                edge_cnt <= edge_cnt + 1'b1;
                rx_sr    <= rx_nxt;
                if (shout) begin
                    mosi  <= tx_sr[BITS-1];
                    tx_sr <= tx_sr << 1;
                end
                if (edge_cnt == LAST_EDGE) state <= SH_IDLE;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R3
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE && !en) |=> state == SH_IDLE);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SH_IDLE && $past(state == SH_IDLE) && $stable(cpol)) |-> sclk == cpol);

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DATA_W     = 8,
    parameter int DIV_W      = 3,
    parameter int NCS        = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [2:0]  cs_n
);
    cfg_t             cfg_q;
    logic [NSTAT-1:0] mask_q;
    logic             ena_q;
    logic             rxovf_q, txovf_q;
    logic [NSTAT-1:0] status;

    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [DATA_W-1:0] tx_head, rx_head, rx_in;
    logic              sh_take, sh_done;

    logic wr_cfg, wr_stat, wr_ien, wr_idis, wr_ena, wr_txd, rd_rxd;

    assign wr_cfg  = reg_wr && reg_addr == OFS_CFG;
    assign wr_stat = reg_wr && reg_addr == OFS_STAT;
    assign wr_ien  = reg_wr && reg_addr == OFS_IEN;
    assign wr_idis = reg_wr && reg_addr == OFS_IDIS;
    assign wr_ena  = reg_wr && reg_addr == OFS_ENA;
    assign wr_txd  = reg_wr && reg_addr == OFS_TXD;
    assign rd_rxd  = reg_rd && reg_addr == OFS_RXD;

    assign tx_push = wr_txd && !tx_full;
    assign tx_pop  = sh_take;
    assign rx_push = sh_done && !rx_full;
    assign rx_pop  = rd_rxd && !rx_empty;

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_in),
        .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

    spim_shifter #(.BITS(DATA_W), .DIVW(DIV_W)) u_shift (
        .clk(clk), .rst(rst), .en(ena_q), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha),
        .div(cfg_q.div), .tx_avail(!tx_empty), .tx_byte(tx_head),
        .tx_take(sh_take), .rx_push(sh_done), .rx_byte(rx_in),
        .miso(miso), .sclk(sclk), .mosi(mosi));

    spim_csdec #(.NCS(NCS)) u_cs (
        .sel(cfg_q.sel[NCS-1:0]), .cs_n(cs_n));

    always_comb begin
        status            = '0;
        status[ST_RXOVF]  = rxovf_q;
        status[ST_TXNF]   = !tx_full;
        status[ST_TXFULL] = tx_full;
        status[ST_RXNE]   = !rx_empty;
        status[ST_RXFULL] = rx_full;
        status[ST_TXOVF]  = txovf_q;
    end

    assign irq = |(status & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            mask_q  <= '0;
            ena_q   <= 1'b0;
            rxovf_q <= 1'b0;
            txovf_q <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= cfg_from_word(reg_wdata[15:0]);
            if (wr_ena)  ena_q  <= reg_wdata[0];
            if (wr_ien)  mask_q <= mask_q | reg_wdata[NSTAT-1:0];
            if (wr_idis) mask_q <= mask_q & ~reg_wdata[NSTAT-1:0];
            if (wr_stat && reg_wdata[ST_RXOVF]) rxovf_q <= 1'b0;
            if (wr_stat && reg_wdata[ST_TXOVF]) txovf_q <= 1'b0;
            if (sh_done && rx_full) rxovf_q <= 1'b1;
            if (wr_txd && tx_full)  txovf_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_CFG:  reg_rdata = {16'h0, cfg_q};
                OFS_STAT: reg_rdata = {{(REG_DW-NSTAT){1'b0}}, status};
                OFS_IMSK: reg_rdata = {{(REG_DW-NSTAT){1'b0}}, mask_q};
                OFS_ENA:  reg_rdata = {31'h0, ena_q};
                OFS_RXD:  reg_rdata = rx_empty ? '0 : {{(REG_DW-DATA_W){1'b0}}, rx_head};
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R7
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && rx_empty) |-> reg_rdata == 32'd0);
    // R11
    mask_clear_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_IDIS && reg_wdata[NSTAT-1:0] == 7'h7F) |=> !irq);
    // R2
    select_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr) |-> $stable(cs_n));

endmodule

// File: tb/spi_master_ctrl_test.sv
module spi_master_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi, miso;
    logic [2:0]  cs_n;

    int checks = 0;
    int fails  = 0;

    logic       inv_b = 1'b0, cpol_b = 1'b0, cpha_b = 1'b0, mon_on = 1'b0;
    logic [7:0] mon_sr = '0;
    int         mon_bits = 0;
    int         hi_cnt = 0;

    always #10 clk = ~clk;

    assign miso = inv_b ? ~mosi : mosi;

    spi_master_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    always @(sclk) begin
        if (mon_on && ((sclk != cpol_b) ^ cpha_b)) begin
            mon_sr   = {mon_sr[6:0], mosi};
            mon_bits = mon_bits + 1;
        end
    end

    always @(negedge clk) begin
        if (mon_on && sclk != cpol_b) hi_cnt = hi_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            repeat (n) @(negedge clk);
            rd(6'h04, s);
            if (s[4]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h00, v); check(v == 32'h3C00, "R1 config", v, 32'h3C00);
        rd(6'h04, v); check(v == 32'h04, "R1 status", v, 32'h04);
        rd(6'h10, v); check(v == 32'h0, "R1 mask", v, 32'h0);
        check(cs_n == 3'b111 && sclk == 1'b0 && irq == 1'b0, "R1 pins",
              {cs_n, sclk, irq}, 32'h1C);
    endtask

    task automatic t_select();
        logic [3:0] pats [6] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1100, 4'b1111};
        logic [2:0] exps [6] = '{3'b110, 3'b101, 3'b011, 3'b111, 3'b110, 3'b111};
        for (int i = 0; i < 6; i++) begin
            wr(6'h00, {18'h0, pats[i], 10'h001});
            @(negedge clk);
            check(cs_n == exps[i], "R2 decode", cs_n, exps[i]);
        end
    endtask

    task automatic t_xfer(input bit pol, input bit pha, input logic [2:0] code,
                          input logic [7:0] b, input bit inv);
        logic [31:0] v;
        wr(6'h14, 32'h0);
        cpol_b = pol; cpha_b = pha; inv_b = inv;
        wr(6'h00, {18'h0, 4'b1011, 4'h0, code, pha, pol, 1'b1});
        wr(6'h14, 32'h1);
        repeat (2) @(negedge clk);
        mon_bits = 0; hi_cnt = 0; mon_on = 1'b1;
        wr(6'h1C, {24'h0, b});
        wait_rx(4);
        mon_on = 1'b0;
        rd(6'h20, v);
        check(v == {24'h0, inv ? ~b : b}, "R5 received byte", v, {24'h0, inv ? ~b : b});
        check(mon_sr == b && mon_bits == 8, "R4 mosi on sampling edges",
              {mon_bits[7:0], mon_sr}, {8'd8, b});
        check(hi_cnt == (8 << code), "R6 divisor", hi_cnt, 8 << code);
        check(sclk == pol && cs_n == 3'b011, "R4 idle level", {cs_n, sclk}, {pol ? 4'b0111 : 4'b0110});
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(6'h14, 32'h0);
        wr(6'h00, 32'h0000_3C01);
        cpol_b = 0; cpha_b = 0; inv_b = 0;
        wr(6'h1C, 32'h5A);
        repeat (40) @(negedge clk);
        rd(6'h04, v);
        check(v[4] == 1'b0 && sclk == 1'b0, "R3 no shift while off", {v[4], sclk}, 0);
        wr(6'h14, 32'h1);
        wait_rx(4);
        rd(6'h20, v);
        check(v == 32'h5A, "R3 shifts once on", v, 32'h5A);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        rd(6'h20, v); check(v == 0, "R7 empty read", v, 0);
        rd(6'h04, v); check(v[4] == 1'b0, "R7 stays empty", v[4], 0);
    endtask

    task automatic t_burst();
        logic [31:0] v;
        for (int i = 0; i < 5; i++) wr(6'h1C, 32'hC0 + i);
        repeat (200) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            rd(6'h20, v);
            check(v == 32'hC0 + i, "R8 order", v, 32'hC0 + i);
        end
        rd(6'h20, v); check(v == 0, "R8 drained", v, 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(6'h14, 32'h0);
        for (int i = 0; i < 129; i++) wr(6'h1C, i);
        rd(6'h04, v);
        check(v[6:2] == 5'b10010, "R9 tx full flags", v, 32'h48);
        wr(6'h04, 32'h40);
        rd(6'h04, v);
        check(v[6:2] == 5'b00010, "R10 w1c tx overflow", v, 32'h08);
        wr(6'h14, 32'h1);
        repeat (2600) @(negedge clk);
        rd(6'h04, v);
        check(v[5:4] == 2'b11 && v[0] == 1'b0, "R9 rx full", v, 32'h34);
        wr(6'h1C, 32'hEE);
        repeat (40) @(negedge clk);
        rd(6'h04, v);
        check(v[0] == 1'b1, "R9 rx overflow sticky", v[0], 1);
        wr(6'h04, 32'h3C);
        rd(6'h04, v);
        check(v[0] == 1'b1 && v[5] == 1'b1, "R10 live bits untouched", v, 32'h35);
        wr(6'h04, 32'h01);
        rd(6'h04, v);
        check(v[0] == 1'b0, "R10 w1c rx overflow", v[0], 0);
        for (int i = 0; i < 128; i++) begin
            rd(6'h20, v);
            if (i == 0 || i == 127) check(v == i, "R8 deep order", v, i);
        end
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(6'h08, 32'h10);
        @(negedge clk);
        check(irq == 1'b0, "R11 no source", irq, 0);
        wr(6'h1C, 32'h33);
        wait_rx(4);
        check(irq == 1'b1, "R11 irq on", irq, 1);
        rd(6'h10, v); check(v == 32'h10, "R11 mask read", v, 32'h10);
        wr(6'h0C, 32'h7F);
        @(negedge clk);
        check(irq == 1'b0, "R11 irq off", irq, 0);
        rd(6'h10, v); check(v == 0, "R11 mask cleared", v, 0);
        rd(6'h20, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select();
        t_xfer(0, 0, 3'd0, 8'hA5, 0);
        t_xfer(0, 1, 3'd2, 8'h3C, 0);
        t_xfer(1, 0, 3'd1, 8'h81, 1);
        t_xfer(1, 1, 3'd3, 8'h6E, 0);
        t_gate();
        t_empty();
        t_burst();
        t_overflow();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule